// File: doc/BRIEF.md
# Flash Command Interface and Status Register

This block is the command front end of a simple NOR-style flash device. A host writes 8-bit command bytes over a strobed bus with chip-select, output-enable and write-enable lines. The block decodes those bytes and runs single-byte writes and block erases through an internal sequencer. It keeps an 8-bit status register and decides whether a read cycle returns array data or status.

There is no real cell array. Each program or erase attempt lasts a fixed, parameterised number of clock cycles. When an attempt ends, a verify input says whether it succeeded. After a parameterised number of failed attempts the operation stops and flags an error. A single input reports whether the programming voltage is present. The block samples it only on the cycle that launches an operation.

The error flags are sticky and only the host can clear them. Once the voltage-missing flag is set, the block refuses every later write or erase until that flag is cleared. A status value on the data pins stays frozen until the host releases and re-asserts a read strobe.

Top module: `flash_cmd_if`

## Requirements
- R1: The status byte has this layout: bit 7 = ready (1 when no operation is running), bit 6 = erase suspended, bit 5 = erase error, bit 4 = write error, bit 3 = programming voltage missing. Bits 2..0 always read 0.
- R2: A synchronous reset sets these values: status 80h, read mode = array data, no operation pending.
- R3: From idle, these command bytes act as follows: FFh selects array reads, 70h selects status reads, and 50h clears status bits 5, 4 and 3.
- R4: Byte 40h or 10h, followed by any data byte, launches a write. The arming command switches reads to status with no further command.
- R5: Byte 20h followed by D0h launches a block erase. Any other second byte abandons the sequence and starts no operation. A lone D0h in idle has no effect.
- R6: Each attempt lasts BUSY_CYC clock cycles, and verify_ok is sampled at the end of each attempt. An operation whose attempt k passes drives rdy high exactly k*BUSY_CYC cycles after the launching write.
- R7: After MAX_TRY failed attempts the operation ends and rdy returns high. A failed write sets bit 4; a failed erase sets bit 5.
- R8: Bits 5, 4 and 3 stay set through later operations, including successful ones, until 50h or reset clears them.
- R9: vpp_ok is sampled only on the cycle of the data byte or the erase confirm. If it is low, no operation starts and bit 3 is set. Changes to vpp_ok during a running operation have no effect.
- R10: While bit 3 is set, a data byte or erase confirm starts no operation, and rdy stays high.
- R11: Byte B0h during an erase suspends it: bits 7 and 6 read 1 and the cycle count freezes. Byte D0h resumes the erase, which finishes after the remaining cycles only. Bit 6 clears on resume.
- R12: A status read latches its value when the read strobes (bus_cs and bus_oe) first become active. The value holds until either strobe is dropped and raised again. An array read follows arr_rdata on every cycle.
- R13: rdy equals status bit 7 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_we | input | 1 | Write enable, active high; one byte per cycle while asserted with bus_cs |
| bus_din | input | 8 | Command or data byte |
| arr_rdata | input | 8 | Data from the array model, returned in array read mode |
| vpp_ok | input | 1 | Programming voltage present |
| verify_ok | input | 1 | Verify result of the current attempt |
| bus_dout | output | 8 | Registered read data; 0 when not reading |
| rdy | output | 1 | High when no operation is running |

## Verification
On every cycle the assertions check several invariants: the sticky error flags hold unless a clear is issued, and a frozen status read never changes while the strobes stay active. They also check that the attempt counter is frozen during suspend and that a launch attempted with the voltage flag set always falls back to idle. The bench scenarios cover the remaining behaviour. They show the exact cycle on which rdy rises for each attempt count, and which error bit a failure leaves behind. They also show the status value seen after a strobe toggle, the time remaining after a resume, and the result of an abandoned erase sequence.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_WRITE_A     = 8'h40;
  localparam logic [7:0] CMD_WRITE_B     = 8'h10;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_ARM, ST_ER_ARM, ST_WR_RUN, ST_ER_RUN, ST_ER_HOLD
  } state_t;

  typedef enum logic {RM_ARRAY, RM_STATUS} rmode_t;
endpackage

// File: rtl/fci_engine.sv
module fci_engine #(
  parameter int BUSY_CYC = 4,
  parameter int MAX_TRY  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic hold,
  input  logic verify_ok,
  output logic done_ok,
  output logic done_fail
);
  localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam int TW = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

  logic          running;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic          last;

  assign last      = running && !hold && (cnt == CW'(BUSY_CYC - 1));
  assign done_ok   = last && verify_ok;
  assign done_fail = last && !verify_ok && (tries == TW'(MAX_TRY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      tries   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      tries   <= '0;
    end else if (running && !hold) begin
      if (last) begin
        cnt <= '0;
        if (done_ok || done_fail) running <= 1'b0;
        else                      tries   <= tries + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < (CW+1)'(BUSY_CYC));
  assert_try_bound_R7: assert property (@(posedge clk) disable iff (rst)
    running |-> ({1'b0, tries} < (TW+1)'(MAX_TRY)));
  assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    (running && hold && !start) |=> ($stable(cnt) && $stable(tries)));
endmodule

// File: rtl/fci_status.sv
module fci_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       susp,
  input  logic       set_vpp,
  input  logic       set_wr_err,
  input  logic       set_er_err,
  input  logic       clr,
  output logic [7:0] sr
);
  logic er_err, wr_err, vpp_miss;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      er_err   <= 1'b0;
      wr_err   <= 1'b0;
      vpp_miss <= 1'b0;
    end else begin
      if (set_er_err) er_err   <= 1'b1;
      if (set_wr_err) wr_err   <= 1'b1;
      if (set_vpp)    vpp_miss <= 1'b1;
    end
  end

  assign sr = {~busy, susp, er_err, wr_err, vpp_miss, 3'b000};

  assert_sticky_er_R8: assert property (@(posedge clk) disable iff (rst)
    (er_err && !clr) |=> er_err);
  assert_sticky_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_err && !clr) |=> wr_err);
  assert_sticky_vpp_R8: assert property (@(posedge clk) disable iff (rst)
    (vpp_miss && !clr) |=> vpp_miss);
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!er_err && !wr_err && !vpp_miss));
endmodule

// File: rtl/fci_readout.sv
module fci_readout
  import fci_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       oe,
  input  rmode_t     mode,
  input  logic [7:0] sr,
  input  logic [7:0] arr_in,
  output logic [7:0] dout
);
  logic rd_act, rd_q;
  assign rd_act = cs && oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      dout <= '0;
    end else begin
      rd_q <= rd_act;
      if (!rd_act)
        dout <= '0;
      else if (!rd_q || mode == RM_ARRAY)
        dout <= (mode == RM_STATUS) ? sr : arr_in;
    end
  end

  assert_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_q && mode == RM_STATUS) |=> $stable(dout));
endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       vpp_ok,
  input  logic       vpp_flag,
  input  logic       eng_ok,
  input  logic       eng_fail,
  output state_t     st,
  output rmode_t     rmode,
  output logic       start,
  output logic       set_vpp,
  output logic       set_wr_err,
  output logic       set_er_err,
  output logic       clr
);
  state_t st_nx;
  rmode_t rm_nx;
  logic   launch;

  always_comb begin
    st_nx  = st;
    rm_nx  = rmode;
    launch = 1'b0;
    clr    = 1'b0;
    case (st)
      ST_IDLE: if (wr_stb) begin
        case (wr_byte)
          CMD_READ_ARRAY:  rm_nx = RM_ARRAY;
          CMD_READ_STATUS: rm_nx = RM_STATUS;
          CMD_CLEAR:       clr   = 1'b1;
          CMD_WRITE_A, CMD_WRITE_B: begin
            st_nx = ST_WR_ARM;
            rm_nx = RM_STATUS;
          end
          CMD_ERASE: begin
            st_nx = ST_ER_ARM;
            rm_nx = RM_STATUS;
          end
          default: ;
        endcase
      end
      ST_WR_ARM: if (wr_stb) begin
        st_nx  = ST_IDLE;
        launch = 1'b1;
      end
      ST_ER_ARM: if (wr_stb) begin
        st_nx  = ST_IDLE;
        launch = (wr_byte == CMD_CONFIRM);
      end
      ST_WR_RUN: if (eng_ok || eng_fail) st_nx = ST_IDLE;
      ST_ER_RUN: begin
        if (eng_ok || eng_fail)                         st_nx = ST_IDLE;
        else if (wr_stb && wr_byte == CMD_SUSPEND) begin
          st_nx = ST_ER_HOLD;
          rm_nx = RM_STATUS;
        end
      end
      ST_ER_HOLD: if (wr_stb) begin
        case (wr_byte)
          CMD_CONFIRM: begin
            st_nx = ST_ER_RUN;
            rm_nx = RM_STATUS;
          end
          CMD_READ_ARRAY:  rm_nx = RM_ARRAY;
          CMD_READ_STATUS: rm_nx = RM_STATUS;
          default: ;
        endcase
      end
      default: st_nx = ST_IDLE;
    endcase
    start   = launch && !vpp_flag && vpp_ok;
    set_vpp = launch && !vpp_flag && !vpp_ok;
    if (start) st_nx = (st == ST_WR_ARM) ? ST_WR_RUN : ST_ER_RUN;
  end

  assign set_wr_err = eng_fail && (st == ST_WR_RUN);
  assign set_er_err = eng_fail && (st == ST_ER_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      rmode <= RM_ARRAY;
    end else begin
      st    <= st_nx;
      rmode <= rm_nx;
    end
  end

  assert_refuse_R10: assert property (@(posedge clk) disable iff (rst)
    (vpp_flag && wr_stb && (st == ST_WR_ARM || st == ST_ER_ARM)) |=> (st == ST_IDLE));
  assert_hold_stays_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ER_HOLD && !(wr_stb && wr_byte == CMD_CONFIRM)) |=> (st == ST_ER_HOLD));
  assert_status_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR_ARM || st == ST_ER_ARM) |-> (rmode == RM_STATUS));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int BUSY_CYC = 4,
  parameter int MAX_TRY  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_cs,
  input  logic       bus_oe,
  input  logic       bus_we,
  input  logic [7:0] bus_din,
  input  logic [7:0] arr_rdata,
  input  logic       vpp_ok,
  input  logic       verify_ok,
  output logic [7:0] bus_dout,
  output logic       rdy
);
  state_t     st;
  rmode_t     rmode;
  logic       wr_stb, start, set_vpp, set_wr_err, set_er_err, clr;
  logic       eng_ok, eng_fail, busy, susp;
  logic [7:0] sr;

  assign wr_stb = bus_cs && bus_we;
  assign busy   = (st == ST_WR_RUN) || (st == ST_ER_RUN);
  assign susp   = (st == ST_ER_HOLD);
  assign rdy    = sr[7];

  fci_seq u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(bus_din),
    .vpp_ok(vpp_ok), .vpp_flag(sr[3]), .eng_ok(eng_ok), .eng_fail(eng_fail),
    .st(st), .rmode(rmode), .start(start), .set_vpp(set_vpp),
    .set_wr_err(set_wr_err), .set_er_err(set_er_err), .clr(clr)
  );

  fci_engine #(.BUSY_CYC(BUSY_CYC), .MAX_TRY(MAX_TRY)) u_engine (
    .clk(clk), .rst(rst), .start(start), .hold(susp), .verify_ok(verify_ok),
    .done_ok(eng_ok), .done_fail(eng_fail)
  );

  fci_status u_status (
    .clk(clk), .rst(rst), .busy(busy), .susp(susp), .set_vpp(set_vpp),
    .set_wr_err(set_wr_err), .set_er_err(set_er_err), .clr(clr), .sr(sr)
  );

  fci_readout u_readout (
    .clk(clk), .rst(rst), .cs(bus_cs), .oe(bus_oe), .mode(rmode),
    .sr(sr), .arr_in(arr_rdata), .dout(bus_dout)
  );

  assert_launch_busy_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> !rdy);
  assert_fail_flag_R7: assert property (@(posedge clk) disable iff (rst)
    eng_fail |=> (rdy && (sr[5] || sr[4])));
endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  localparam int B = 4;
  localparam int M = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, oe = 1'b0, we = 1'b0;
  logic [7:0] din = '0, arr = '0;
  logic       vpp = 1'b1, ver = 1'b0;
  logic [7:0] dout;
  logic       rdy;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  flash_cmd_if #(.BUSY_CYC(B), .MAX_TRY(M)) i_flash_cmd_if (
    .clk(clk), .rst(rst), .bus_cs(cs), .bus_oe(oe), .bus_we(we), .bus_din(din),
    .arr_rdata(arr), .vpp_ok(vpp), .verify_ok(ver), .bus_dout(dout), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    cs = 1'b1; we = 1'b1; din = b;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    cs = 1'b1; oe = 1'b1;
    @(negedge clk);
    v = dout;
    cs = 1'b0; oe = 1'b0;
    @(negedge clk);
  endtask

  // Launch an operation whose attempt k first passes (k > M: never passes).
  task automatic run_op(input bit erase, input int k, input string req);
    int fin;
    fin = ((k < M) ? k : M) * B;
    wr(erase ? 8'h20 : 8'h40);
    cs = 1'b1; we = 1'b1; din = erase ? 8'hD0 : 8'h5A; ver = 1'b0;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    for (int i = 1; i <= fin; i++) begin
      ver = (i > (k - 1) * B);
      @(negedge clk);
      if (i == fin - 1) chk({req, " R6 busy before end"}, {7'd0, rdy}, 8'd0);
      if (i == fin)     chk({req, " R6 ready at end"}, {7'd0, rdy}, 8'd1);
    end
    ver = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] ebit;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    arr = 8'hC3;
    chk("R2 rdy after reset", {7'd0, rdy}, 8'd1);
    rd(v); chk("R2 array mode after reset", v, 8'hC3);
    wr(8'h70); rd(v); chk("R1 R3 status after reset", v, 8'h80);

    // R6 R7: sweep of attempt counts for write and erase
    for (int e = 0; e < 2; e++) begin
      ebit = (e != 0) ? 8'h20 : 8'h10;
      for (int k = 1; k <= M + 1; k++) begin
        wr(8'h50);
        run_op(e != 0, k, "R7 sweep");
        rd(v); chk("R7 error bit after op", v, 8'h80 | ((k > M) ? ebit : 8'h00));
      end
    end

    // R8: sticky bits survive later successful operations
    wr(8'h50);
    run_op(1'b0, M + 1, "R8");
    run_op(1'b1, M + 1, "R8");
    run_op(1'b0, 1, "R8");
    rd(v); chk("R8 sticky after success", v, 8'hB0);
    wr(8'h50); rd(v); chk("R3 clear status", v, 8'h80);

    // R12: frozen status read
    wr(8'h10);
    cs = 1'b1; we = 1'b1; din = 8'h33; ver = 1'b1;
    @(negedge clk);
    we = 1'b0; oe = 1'b1;
    @(negedge clk);
    chk("R12 snapshot busy", dout, 8'h00);
    for (int j = 0; j < 2 * B; j++) begin
      @(negedge clk);
      chk("R12 frozen while held", dout, 8'h00);
    end
    chk("R13 rdy high during frozen read", {7'd0, rdy}, 8'd1);
    oe = 1'b0; @(negedge clk); oe = 1'b1; @(negedge clk);
    chk("R12 refresh after oe toggle", dout, 8'h80);
    cs = 1'b0; @(negedge clk); cs = 1'b1; @(negedge clk);
    chk("R12 refresh after cs toggle", dout, 8'h80);
    cs = 1'b0; oe = 1'b0; ver = 1'b0;
    @(negedge clk);

    // R12 R3: array reads follow input each cycle
    wr(8'hFF);
    arr = 8'hA5; cs = 1'b1; oe = 1'b1;
    @(negedge clk); chk("R12 array read", dout, 8'hA5);
    arr = 8'h3C;
    @(negedge clk); chk("R12 array tracks", dout, 8'h3C);
    cs = 1'b0; oe = 1'b0;
    @(negedge clk);

    // R9 R10: voltage missing
    vpp = 1'b0;
    wr(8'h40); wr(8'h11);
    chk("R9 no start when vpp low", {7'd0, rdy}, 8'd1);
    rd(v); chk("R9 vpp bit set", v, 8'h88);
    vpp = 1'b1;
    wr(8'h40); wr(8'h22);
    chk("R10 write refused", {7'd0, rdy}, 8'd1);
    wr(8'h20); wr(8'hD0);
    chk("R10 erase refused", {7'd0, rdy}, 8'd1);
    rd(v); chk("R10 status unchanged", v, 8'h88);
    wr(8'h50);
    wr(8'h40); wr(8'h22);
    chk("R10 accepted after clear", {7'd0, rdy}, 8'd0);
    vpp = 1'b0; ver = 1'b1;
    repeat (B + 1) @(negedge clk);
    vpp = 1'b1; ver = 1'b0;
    rd(v); chk("R9 vpp change during op ignored", v, 8'h80);

    // R5: abandoned erase and lone confirm
    wr(8'h20); wr(8'h55);
    chk("R5 abandoned erase", {7'd0, rdy}, 8'd1);
    rd(v); chk("R5 status after abandon", v, 8'h80);
    wr(8'hD0);
    chk("R5 lone confirm ignored", {7'd0, rdy}, 8'd1);

    // R11: suspend and resume
    ver = 1'b1;
    wr(8'h20);
    cs = 1'b1; we = 1'b1; din = 8'hD0;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    @(negedge clk);
    wr(8'hB0);
    chk("R11 rdy while suspended", {7'd0, rdy}, 8'd1);
    repeat (5) @(negedge clk);
    rd(v); chk("R11 suspend status", v, 8'hC0);
    wr(8'hD0);
    chk("R11 busy after resume", {7'd0, rdy}, 8'd0);
    repeat (B - 3) @(negedge clk);
    chk("R11 still busy before remainder", {7'd0, rdy}, 8'd0);
    @(negedge clk);
    chk("R11 done after remainder", {7'd0, rdy}, 8'd1);
    rd(v); chk("R11 suspend bit cleared", v, 8'h80);
    ver = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule